// File: doc/BRIEF.md
# Programmable High-Current Trip Delay Timer

This block decides when a battery pack has drawn too much current for too long. Software writes a 6-bit delay code into an 8-bit configuration register on the CPU clock. The code is handed across to a slow, always-running oscillator domain. In that domain two independent protection channels, one for discharge and one for charge, each watch a high-current detect input. When the detect stays asserted for the programmed time, the channel raises a trip output that switches off its FET.

Delay is measured in 2 ms ticks produced by a prescaler on the slow clock. Because a detect event can start anywhere within a tick period, each code gives a window of uncertainty one tick wide. Code 0 behaves like code 1. Every accepted write opens a guard window. The window lasts for the cross-domain handshake: three slow-clock edges followed by three CPU edges. Writes that arrive during this window are dropped silently.

A `busy` output reports the guard window. After a channel's FET enable rises, the channel spends a short arming period during which it ignores its detect input. A trip latches and is held until the FET enable of that channel is taken low.

Top module: `hc_trip_timer`

## Requirements
- R1: After reset, the read port returns 0x01, `busy` is low, both trip outputs are low, and the delay behaves as code 1.
- R2: Read bits 7:6 are always zero. Only write bits 5:0 are stored, so writing 0xC3 reads back and acts as 0x03.
- R3: A write while `busy` is low is accepted. The new code appears on `rd_data` and `busy` is high from the next CPU edge. `busy` stays high for three slow-clock edges plus three CPU edges, then falls by itself.
- R4: A write while `busy` is high is dropped. Neither the readback nor the delay used by the channels changes.
- R5: For a code n from 1 to 63, with the channel armed and detect held high, the trip appears between (n-1)*TICK_DIV+1 and n*TICK_DIV slow-clock edges after detect is first sampled. One tick is TICK_DIV slow cycles.
- R6: Code 0 gives the same delay window as code 1.
- R7: If detect falls before the trip, that channel's count clears, and a later assertion needs the full delay again.
- R8: A trip stays high while the FET enable stays high, even after detect falls. It clears on the slow edge after the FET enable goes low, and does not return on re-enable without a new detect.
- R9: After a FET enable rises, detect is ignored for ARM_CYCLES slow cycles. With code 1 and detect already high, the trip therefore comes between ARM_CYCLES+1 and ARM_CYCLES+TICK_DIV edges after the enable.
- R10: While a channel's FET enable is low, that channel never trips, whatever its detect input does.
- R11: Bit 0 of `fet_en`, `detect` and `trip` is the discharge channel and bit 1 is the charge channel. The two channels share one delay code but time and trip independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU bus clock |
| cpu_rst_n | input | 1 | Active-low reset, CPU domain |
| slow_clk | input | 1 | Slow always-on oscillator clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | 8 | Write data; bits 5:0 are the delay code |
| rd_data | output | 8 | Configuration readback; bits 7:6 are zero |
| busy | output | 1 | High during the guard window after an accepted write |
| fet_en | input | 2 | FET enable per channel (bit 0 discharge, bit 1 charge) |
| detect | input | 2 | High-current detect per channel |
| trip | output | 2 | Latched trip per channel |

## Verification
The bench sweeps the codes at both ends of the range and in the middle, including 0 and 1. It measures each trip time against its one-tick window, so a design that counts one tick too many or too few, or that gives code 0 no delay, lands outside the window. It writes during the guard window and then measures the delay; a design that lets the dropped write through would trip about 58 ticks early. Further tests interrupt detect partway through the delay, remove the FET enable after a trip, and raise the enable with detect already high. These catch a counter that keeps its partial count, a trip that clears without help or never clears, and a channel that acts before its arming period ends.

// File: rtl/hct_pkg.sv
package hct_pkg;
    localparam int REG_W = 8;
    localparam int CODE_W = 6;
    localparam int NCH = 2;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(1);
endpackage

// File: rtl/hct_cfg_port.sv
module hct_cfg_port
    import hct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ack_tgl,
    output logic [REG_W-1:0]  rd_data,
    output logic              busy,
    output logic [CODE_W-1:0] code,
    output logic              req_tgl
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              req;
        logic              ack_s1;
        logic              ack_s2;
        logic              busy;
    } cfg_st_t;

    cfg_st_t st_q, st_d;
    logic    accept;
    logic    unused_rsvd;

    assign unused_rsvd = ^wr_data[REG_W-1:CODE_W];

    always_comb begin
        st_d        = st_q;
        accept      = wr_en && !st_q.busy;
        st_d.ack_s1 = ack_tgl;
        st_d.ack_s2 = st_q.ack_s1;
        if (accept) begin
            st_d.code = wr_data[CODE_W-1:0];
            st_d.req  = ~st_q.req;
            st_d.busy = 1'b1;
        end else if (st_q.busy && (st_q.ack_s2 == st_q.req)) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code   <= CODE_RST;
            st_q.req    <= 1'b0;
            st_q.ack_s1 <= 1'b0;
            st_q.ack_s2 <= 1'b0;
            st_q.busy   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = {{(REG_W-CODE_W){1'b0}}, st_q.code};
    assign busy    = st_q.busy;
    assign code    = st_q.code;
    assign req_tgl = st_q.req;

    // R3: an accepted write lands and opens the window
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> (busy && code == $past(wr_data[CODE_W-1:0])));
    // R3: the window lasts more than one cycle
    p_busy_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    // R4: writes inside the window leave the code and handshake untouched
    p_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(code) && $stable(req_tgl)));
endmodule

// File: rtl/hct_xfer.sv
module hct_xfer
    import hct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out,
    output logic              ack_tgl
);
    typedef struct packed {
        logic              req_s1;
        logic              req_s2;
        logic              req_s3;
        logic [CODE_W-1:0] code;
    } xf_st_t;

    xf_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.req_s1 = req_tgl;
        st_d.req_s2 = st_q.req_s1;
        st_d.req_s3 = st_q.req_s2;
        if (st_q.req_s2 != st_q.req_s3) begin
            st_d.code = code_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req_s1 <= 1'b0;
            st_q.req_s2 <= 1'b0;
            st_q.req_s3 <= 1'b0;
            st_q.code   <= CODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_out = st_q.code;
    assign ack_tgl  = st_q.req_s3;

    // R4: the slow-side code only moves when a new request arrives
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req_s2 == st_q.req_s3) |=> $stable(code_out));
endmodule

// File: rtl/hct_prescaler.sv
module hct_prescaler #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q, cnt_d;
            logic          wrap;

            always_comb begin
                wrap  = (cnt_q == CW'(DIV-1));
                cnt_d = wrap ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = wrap;

            // R5: ticks are isolated, one per period
            p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/hct_channel.sv
module hct_channel
    import hct_pkg::*;
#(
    parameter int ARM_CYCLES = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    input  logic              fet_en,
    input  logic              detect,
    output logic              trip
);
    localparam int AW = $clog2(ARM_CYCLES + 1);

    typedef struct packed {
        logic [AW-1:0]     arm_cnt;
        logic              armed;
        logic [CODE_W-1:0] cnt;
        logic              trip;
    } ch_st_t;

    ch_st_t            st_q, st_d;
    logic [CODE_W-1:0] limit;
    logic [CODE_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        limit   = (code == '0) ? CODE_W'(1) : code;
        cnt_inc = st_q.cnt + 1'b1;
        if (!fet_en) begin
            st_d = '0;
        end else if (!st_q.armed) begin
            if (st_q.arm_cnt == AW'(ARM_CYCLES-1)) st_d.armed = 1'b1;
            else                                   st_d.arm_cnt = st_q.arm_cnt + 1'b1;
        end else if (!st_q.trip) begin
            if (!detect) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (cnt_inc == limit) begin
                    st_d.trip = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip = st_q.trip;

    // R8: a trip holds while the FET stays enabled
    p_trip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && fet_en) |=> trip);
    // R10: a disabled FET leaves no trip behind
    p_fet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fet_en |=> !trip);
    // R9: a trip only starts once armed, with detect high on a tick
    p_trip_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> ($past(st_q.armed) && $past(detect) && $past(tick)));
    // R7: a detect drop empties the count
    p_drop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fet_en && st_q.armed && !detect) |=> (st_q.cnt == '0));
endmodule

// File: rtl/hc_trip_timer.sv
module hc_trip_timer
    import hct_pkg::*;
#(
    parameter int TICK_DIV   = 256,
    parameter int ARM_CYCLES = 26
) (
    input  logic             cpu_clk,
    input  logic             cpu_rst_n,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    input  logic [NCH-1:0]   fet_en,
    input  logic [NCH-1:0]   detect,
    output logic [NCH-1:0]   trip
);
    logic [CODE_W-1:0] code_cpu;
    logic [CODE_W-1:0] code_slow;
    logic              req_tgl;
    logic              ack_tgl;
    logic              tick;

    hct_cfg_port u_cfg (
        .clk     (cpu_clk),
        .rst_n   (cpu_rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ack_tgl (ack_tgl),
        .rd_data (rd_data),
        .busy    (busy),
        .code    (code_cpu),
        .req_tgl (req_tgl)
    );

    hct_xfer u_xfer (
        .clk      (slow_clk),
        .rst_n    (slow_rst_n),
        .req_tgl  (req_tgl),
        .code_in  (code_cpu),
        .code_out (code_slow),
        .ack_tgl  (ack_tgl)
    );

    hct_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (slow_clk),
        .rst_n (slow_rst_n),
        .tick  (tick)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            hct_channel #(.ARM_CYCLES(ARM_CYCLES)) u_ch (
                .clk    (slow_clk),
                .rst_n  (slow_rst_n),
                .tick   (tick),
                .code   (code_slow),
                .fet_en (fet_en[i]),
                .detect (detect[i]),
                .trip   (trip[i])
            );
        end
    endgenerate
endmodule

// File: tb/hc_trip_timer_bench.sv
module hc_trip_timer_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 34;
    localparam int DIV         = 4;
    localparam int ARM         = 3;
    localparam int LIMIT       = 1000;
    localparam int NV          = 7;
    localparam logic [7:0] VEC_CODE [NV] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h3E, 8'h3F};
    localparam int         VEC_N    [NV] = '{1, 1, 2, 3, 7, 62, 63};

    logic       cpu_clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic [1:0] fet_en = '0;
    logic [1:0] detect = '0;
    logic [1:0] trip;
    int         checks = 0;
    int         errors = 0;

    hc_trip_timer #(.TICK_DIV(DIV), .ARM_CYCLES(ARM)) u_hc_trip_timer (
        .cpu_clk    (cpu_clk),
        .cpu_rst_n  (rst_n),
        .slow_clk   (slow_clk),
        .slow_rst_n (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .busy       (busy),
        .fet_en     (fet_en),
        .detect     (detect),
        .trip       (trip)
    );

    always #(CLK_PERIOD/2)  cpu_clk  = ~cpu_clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_win(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(negedge cpu_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 200) begin
            @(negedge cpu_clk);
            n++;
        end
    endtask

    task automatic rearm(input int ch);
        @(negedge slow_clk);
        fet_en[ch] = 1'b0;
        @(negedge slow_clk);
        fet_en[ch] = 1'b1;
        repeat (ARM + 2) @(negedge slow_clk);
    endtask

    task automatic measure(input int ch, output int cyc);
        cyc = -1;
        @(negedge slow_clk);
        detect[ch] = 1'b1;
        for (int i = 1; i <= LIMIT; i++) begin
            @(negedge slow_clk);
            if (trip[ch]) begin
                cyc = i;
                break;
            end
        end
        detect[ch] = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge cpu_clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int cyc;
        int nb;
        repeat (4) @(negedge slow_clk);
        rst_n = 1'b1;
        @(negedge cpu_clk);

        // R1: reset state
        check(rd_data == 8'h01, "R1 reset readback", rd_data, 1);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(trip == 2'b00, "R1 reset trip", trip, 0);
        rearm(0);
        measure(0, cyc);
        check_win("R1 reset delay is code 1", cyc, 1, DIV);

        // R10: FET disabled never trips
        fet_en = 2'b00;
        detect = 2'b11;
        repeat (40) @(negedge slow_clk);
        check(trip == 2'b00, "R10 no trip with FET off", trip, 0);
        detect = 2'b00;

        // R5, R6: table of codes and expected tick counts
        for (int v = 0; v < NV; v++) begin
            cpu_write(VEC_CODE[v]);
            wait_idle(nb);
            check(rd_data == VEC_CODE[v], "R5 table readback", rd_data, VEC_CODE[v]);
            rearm(0);
            measure(0, cyc);
            check_win(v == 0 ? "R6 code 0 window" : "R5 code window", cyc,
                      (VEC_N[v]-1)*DIV + 1, VEC_N[v]*DIV);
        end

        // R2: reserved bits
        cpu_write(8'hC3);
        wait_idle(nb);
        check(rd_data == 8'h03, "R2 reserved bits read zero", rd_data, 3);
        rearm(0);
        measure(0, cyc);
        check_win("R2 reserved bits no effect on delay", cyc, 2*DIV + 1, 3*DIV);

        // R3: guard window ; R4: dropped write
        cpu_write(8'h3F);
        check(busy == 1'b1, "R3 busy after write", busy, 1);
        check(rd_data == 8'h3F, "R3 readback new code", rd_data, 8'h3F);
        cpu_write(8'h05);
        check(rd_data == 8'h3F, "R4 dropped write readback", rd_data, 8'h3F);
        wait_idle(nb);
        check_win("R3 busy length in cpu cycles", nb + 2, 8, 40);
        check(busy == 1'b0, "R3 busy clears", busy, 0);
        check(rd_data == 8'h3F, "R4 readback after window", rd_data, 8'h3F);
        rearm(0);
        measure(0, cyc);
        check_win("R4 dropped write no effect on delay", cyc, 62*DIV + 1, 63*DIV);

        // R7: detect drop restarts the count (code 4: 13..16)
        cpu_write(8'h04);
        wait_idle(nb);
        rearm(0);
        @(negedge slow_clk);
        detect[0] = 1'b1;
        repeat (8) @(negedge slow_clk);
        detect[0] = 1'b0;
        repeat (2) @(negedge slow_clk);
        check(trip[0] == 1'b0, "R7 no trip on short detect", trip[0], 0);
        measure(0, cyc);
        check_win("R7 full delay after drop", cyc, 3*DIV + 1, 4*DIV);

        // R8: sticky trip
        repeat (10) @(negedge slow_clk);
        check(trip[0] == 1'b1, "R8 trip held after detect drop", trip[0], 1);
        fet_en[0] = 1'b0;
        @(negedge slow_clk);
        check(trip[0] == 1'b0, "R8 trip clears with FET off", trip[0], 0);
        fet_en[0] = 1'b1;
        repeat (20) @(negedge slow_clk);
        check(trip[0] == 1'b0, "R8 no trip after re-enable", trip[0], 0);

        // R9: arming delay with detect already high
        cpu_write(8'h01);
        wait_idle(nb);
        @(negedge slow_clk);
        fet_en[0] = 1'b0;
        detect[0] = 1'b1;
        repeat (2) @(negedge slow_clk);
        fet_en[0] = 1'b1;
        cyc = -1;
        for (int i = 1; i <= LIMIT; i++) begin
            @(negedge slow_clk);
            if (trip[0]) begin
                cyc = i;
                break;
            end
        end
        detect[0] = 1'b0;
        check_win("R9 arming delay", cyc, ARM + 1, ARM + DIV);

        // R11: charge channel independent, shared code
        cpu_write(8'h03);
        wait_idle(nb);
        rearm(0);
        rearm(1);
        measure(1, cyc);
        check_win("R11 charge channel window", cyc, 2*DIV + 1, 3*DIV);
        check(trip[0] == 1'b0, "R11 discharge untouched", trip[0], 0);

        finish_run();
    end
endmodule